// File: doc/BRIEF.md
# Serial Audio Port Control and Status Register

This block is the control and status word for one direction of a serial audio port. A chip instantiates it twice, once for transmit and once for receive. It collects event pulses and FIFO level indications from the serial datapath and turns them into readable flags. Each flag has its own interrupt enable, and all of them feed a single interrupt line. The same word holds the controls that the datapath obeys: a DMA request enable, a FIFO flush strobe, a soft reset and a port enable.

The three event flags latch their events and stay set until software writes one to them. These are word start, frame sync error and FIFO error. FIFO error means underrun on transmit and overflow on receive. The two level flags simply follow the datapath after one register stage:
- The warning flag shows an empty transmit FIFO or a full receive FIFO.
- The request flag shows that the FIFO has reached its watermark.

Clearing the port enable does not stop the port at once. The port stays active, and the enable bit keeps reading one, until the datapath reports the end of the current frame.

The register is read through a combinational read bus. It is written through a single-cycle write strobe that carries the whole word.

Top module: `sap_csr`

## Requirements
- R1: After reset, `rd_data` is all zero and `irq`, `dma_req`, `fifo_flush`, `port_rst` and `port_active` are all low.
- R2: An event pulse on `ev_word`, `ev_sync` or `ev_fifo_err` sets its sticky flag. The flags sit at bits 20, 19 and 18 respectively. The flag reads one from the cycle after the pulse, and it stays set with no further events until it is cleared.
- R3: A write with a one at a sticky flag position clears that flag, and a zero there leaves the flag unchanged. If an event arrives in the same cycle as its clear, the flag stays set.
- R4: Bit 17 (warning) and bit 16 (request) show `lvl_warn` and `lvl_req` one cycle after those inputs change. Writes to bits 17 and 16 have no effect on them.
- R5: The interrupt enables are written and read back at bits 8 to 12, in the same order as the flags: bit 8 request, 9 warning, 10 error, 11 sync, 12 word.
- R6: `irq` is high exactly when at least one flag and its own enable are both one.
- R7: `dma_req` is high exactly when the DMA enable at bit 0 is one and the request flag is one.
- R8: A write with a one at bit 25 drives `fifo_flush` high for exactly one cycle. Bit 25 always reads zero.
- R9: While bit 24 is one, `port_rst` is high, it reads back as one, the sticky flags are held clear and the port enable is forced off. The interrupt enables keep their values. Writing zero to bit 24 releases the reset.
- R10: Writing one to bit 31 makes `port_active` high and bit 31 read one. After a write of zero, both stay one until a `frame_end` pulse, and then they drop. A `frame_end` while the enable is still commanded on has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | DATA_W | Write value |
| rd_data | output | DATA_W | Current register readback |
| ev_word | input | 1 | Word start event pulse |
| ev_sync | input | 1 | Frame sync error event pulse |
| ev_fifo_err | input | 1 | FIFO underrun (transmit) or overflow (receive) pulse |
| lvl_warn | input | 1 | FIFO empty (transmit) or full (receive) level |
| lvl_req | input | 1 | FIFO at watermark level |
| frame_end | input | 1 | End of current frame pulse from the datapath |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| fifo_flush | output | 1 | One-cycle FIFO empty strobe |
| port_rst | output | 1 | Reset for the port datapath |
| port_active | output | 1 | Port enabled, including the end-of-frame drain |

## Verification
The bench builds the block with its default parameters: a 32-bit word, enables at bit 8, flags at bit 16, and control bits at 0, 24, 25 and 31. With the enable and flag groups eight bits apart, a clear written to the flag field that wrongly reached the enable field would show up in the enable readback. The same spacing lets a single write carry an enable, a clear and the control bits, so same-cycle event-versus-clear races and reset-while-enabled cases can each be set up with one strobe.

// File: rtl/sap_csr_pkg.sv
package sap_csr_pkg;
  localparam int NFLAG   = 5;
  localparam int NSTICKY = 3;
  // flag order inside the flag and enable groups
  localparam int FL_REQ  = 0;
  localparam int FL_WARN = 1;
  localparam int FL_ERR  = 2;
  localparam int FL_SYNC = 3;
  localparam int FL_WORD = 4;

  // next value of a sticky flag: hold forces clear, a new event beats a clear
  function automatic logic sticky_next(logic cur, logic clr, logic ev, logic hold);
    if (hold) return 1'b0;
    return ev | (cur & ~clr);
  endfunction

  function automatic logic any_irq(logic [NFLAG-1:0] flags, logic [NFLAG-1:0] ie);
    return |(flags & ie);
  endfunction
endpackage

// File: rtl/sap_sticky_bank.sv
module sap_sticky_bank
  import sap_csr_pkg::*;
#(
  parameter int N = NSTICKY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= sticky_next(q, clr[i], ev[i], hold);
    end
    assign flag[i] = q;

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && !hold) |=> flag[i]); // R3
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i] && !hold) |=> flag[i]); // R2
  end
endmodule

// File: rtl/sap_port_enable.sv
module sap_port_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic set_cmd,
  input  logic drop_cmd,
  input  logic frame_end,
  output logic active,
  output logic cmd
);
  logic cmd_q, act_q;
  logic drain_done;

  assign drain_done = !cmd_q && frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      act_q <= 1'b0;
    end else if (hold) begin
      cmd_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      if (set_cmd)       cmd_q <= 1'b1;
      else if (drop_cmd) cmd_q <= 1'b0;
      if (set_cmd)         act_q <= 1'b1;
      else if (drain_done) act_q <= 1'b0;
    end
  end

  assign active = act_q;
  assign cmd    = cmd_q;

  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_end && !hold) |=> active); // R10
  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmd && frame_end && !hold && !set_cmd) |=> !active); // R10
endmodule

// File: rtl/sap_irq_dma.sv
module sap_irq_dma
  import sap_csr_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] ie,
  input  logic             dma_en,
  output logic             irq,
  output logic             dma_req
);
  assign irq     = any_irq(flags, ie);
  assign dma_req = dma_en & flags[FL_REQ];
endmodule

// File: rtl/sap_csr.sv
module sap_csr
  import sap_csr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DMAEN_BIT = 0,
  parameter int IE_LSB    = 8,
  parameter int FLAG_LSB  = 16,
  parameter int SRST_BIT  = 24,
  parameter int FRST_BIT  = 25,
  parameter int PEN_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_word,
  input  logic              ev_sync,
  input  logic              ev_fifo_err,
  input  logic              lvl_warn,
  input  logic              lvl_req,
  input  logic              frame_end,
  output logic              irq,
  output logic              dma_req,
  output logic              fifo_flush,
  output logic              port_rst,
  output logic              port_active
);
  localparam int STICKY_LSB = FLAG_LSB + FL_ERR;

  logic [NFLAG-1:0]   ie_q;
  logic               dmaen_q, srst_q, flush_q;
  logic               warn_q, req_q;
  logic [NSTICKY-1:0] sticky, ev_vec, clr_vec;
  logic [NFLAG-1:0]   flags;
  logic               pen_cmd;
  logic               unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= '0;
      dmaen_q <= 1'b0;
      srst_q  <= 1'b0;
      flush_q <= 1'b0;
      warn_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      warn_q  <= lvl_warn;
      req_q   <= lvl_req;
      flush_q <= wr_en && wr_data[FRST_BIT];
      if (wr_en) begin
        ie_q    <= wr_data[IE_LSB +: NFLAG];
        dmaen_q <= wr_data[DMAEN_BIT];
        srst_q  <= wr_data[SRST_BIT];
      end
    end
  end

  assign ev_vec  = {ev_word, ev_sync, ev_fifo_err};
  assign clr_vec = wr_en ? wr_data[STICKY_LSB +: NSTICKY] : '0;

  sap_sticky_bank #(.N(NSTICKY)) u_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (srst_q),
    .ev   (ev_vec),
    .clr  (clr_vec),
    .flag (sticky)
  );

  sap_port_enable u_pen (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (srst_q),
    .set_cmd  (wr_en && wr_data[PEN_BIT]),
    .drop_cmd (wr_en && !wr_data[PEN_BIT]),
    .frame_end(frame_end),
    .active   (port_active),
    .cmd      (pen_cmd)
  );

  assign flags = {sticky, warn_q, req_q};

  sap_irq_dma u_out (
    .flags  (flags),
    .ie     (ie_q),
    .dma_en (dmaen_q),
    .irq    (irq),
    .dma_req(dma_req)
  );

  assign fifo_flush = flush_q;
  assign port_rst   = srst_q;

  always_comb begin
    rd_data = '0;
    rd_data[DMAEN_BIT]          = dmaen_q;
    rd_data[IE_LSB +: NFLAG]    = ie_q;
    rd_data[FLAG_LSB +: NFLAG]  = flags;
    rd_data[SRST_BIT]           = srst_q;
    rd_data[PEN_BIT]            = port_active;
  end

  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (rd_data[FLAG_LSB + FL_REQ] && rd_data[DMAEN_BIT])); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(rd_data[FLAG_LSB +: NFLAG] & rd_data[IE_LSB +: NFLAG]))); // R6
  AST_FLUSH_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush && !(wr_en && wr_data[FRST_BIT])) |=> !fifo_flush); // R8
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_rst) && port_rst) |-> (rd_data[STICKY_LSB +: NSTICKY] == '0 && !port_active && !pen_cmd)); // R9
endmodule

// File: tb/tb_sap_csr.sv
module tb_sap_csr;
  localparam logic [31:0] DMAEN = 32'h1;
  localparam logic [31:0] SRST  = 32'h1 << 24;
  localparam logic [31:0] FRST  = 32'h1 << 25;
  localparam logic [31:0] PEN   = 32'h1 << 31;

  function automatic logic [31:0] ie_bit(int i);
    return 32'h1 << (8 + i);
  endfunction
  function automatic logic [31:0] fl_bit(int i);
    return 32'h1 << (16 + i);
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic ev_word = 0, ev_sync = 0, ev_fifo_err = 0, lvl_warn = 0, lvl_req = 0, frame_end = 0;
  logic irq, dma_req, fifo_flush, port_rst, port_active;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sap_csr dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_word(ev_word), .ev_sync(ev_sync), .ev_fifo_err(ev_fifo_err),
    .lvl_warn(lvl_warn), .lvl_req(lvl_req), .frame_end(frame_end),
    .irq(irq), .dma_req(dma_req), .fifo_flush(fifo_flush),
    .port_rst(port_rst), .port_active(port_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 outputs", {27'h0, irq, dma_req, fifo_flush, port_rst, port_active}, 32'h0);
  endtask

  task automatic t_sticky;
    @(negedge clk); ev_word = 1;
    @(negedge clk); ev_word = 0;
    chk("R2 word set", rd_data & fl_bit(4), fl_bit(4));
    idle(3);
    chk("R2 word held", rd_data & fl_bit(4), fl_bit(4));
    @(negedge clk); ev_sync = 1; ev_fifo_err = 1;
    @(negedge clk); ev_sync = 0; ev_fifo_err = 0;
    chk("R2 all sticky", rd_data[20:16], 5'b11100);
  endtask

  task automatic t_w1c;
    write(fl_bit(4));
    chk("R3 word cleared only", rd_data[20:16], 5'b01100);
    write(32'h0);
    chk("R3 zero keeps", rd_data[20:16], 5'b01100);
    @(negedge clk); ev_sync = 1; wr_en = 1; wr_data = fl_bit(3);
    @(negedge clk); ev_sync = 0; wr_en = 0; wr_data = '0;
    chk("R3 event beats clear", rd_data[20:16], 5'b01100);
    write(fl_bit(3) | fl_bit(2));
    chk("R3 both cleared", rd_data[20:16], 5'b00000);
  endtask

  task automatic t_live;
    @(negedge clk); lvl_warn = 1;
    @(negedge clk);
    chk("R4 warn follows", rd_data[17], 1'b1);
    write(fl_bit(1) | fl_bit(0));
    chk("R4 write ignored", rd_data[17:16], 2'b10);
    lvl_warn = 0;
    @(negedge clk);
    chk("R4 warn drops", rd_data[17], 1'b0);
  endtask

  task automatic t_irq;
    write(ie_bit(2));
    chk("R5 enable readback", rd_data[12:8], 5'b00100);
    chk("R6 no flag no irq", irq, 1'b0);
    @(negedge clk); ev_fifo_err = 1;
    @(negedge clk); ev_fifo_err = 0;
    chk("R6 err irq", irq, 1'b1);
    write(ie_bit(2) | fl_bit(2));
    chk("R6 cleared irq", irq, 1'b0);
    write(ie_bit(0));
    chk("R5 req enable readback", rd_data[12:8], 5'b00001);
    lvl_req = 1; @(negedge clk);
    chk("R6 req irq", irq, 1'b1);
    lvl_req = 0; @(negedge clk);
    chk("R6 req irq drops", irq, 1'b0);
    write(32'h0);
  endtask

  task automatic t_dma;
    lvl_req = 1; @(negedge clk);
    chk("R7 dma gated off", dma_req, 1'b0);
    write(DMAEN);
    chk("R7 dma on", dma_req, 1'b1);
    lvl_req = 0; @(negedge clk);
    chk("R7 dma follows level", dma_req, 1'b0);
    write(32'h0);
  endtask

  task automatic t_flush;
    write(FRST);
    chk("R8 flush pulse", fifo_flush, 1'b1);
    chk("R8 reads zero", rd_data[25], 1'b0);
    @(negedge clk);
    chk("R8 flush one cycle", fifo_flush, 1'b0);
  endtask

  task automatic t_srst;
    write(PEN);
    @(negedge clk); ev_fifo_err = 1;
    @(negedge clk); ev_fifo_err = 0;
    write(SRST | PEN | ie_bit(2));
    chk("R9 port_rst", port_rst, 1'b1);
    chk("R9 readback", rd_data[24], 1'b1);
    @(negedge clk); ev_fifo_err = 1;
    @(negedge clk); ev_fifo_err = 0;
    chk("R9 flags held clear", rd_data[20:18], 3'b000);
    chk("R9 port off", {rd_data[31], port_active}, 2'b00);
    chk("R9 enables kept", rd_data[12:8], 5'b00100);
    write(32'h0);
    chk("R9 released", port_rst, 1'b0);
    @(negedge clk); ev_fifo_err = 1;
    @(negedge clk); ev_fifo_err = 0;
    chk("R9 flags work again", rd_data[18], 1'b1);
    write(fl_bit(2));
  endtask

  task automatic t_pen;
    write(PEN);
    chk("R10 active", {rd_data[31], port_active}, 2'b11);
    @(negedge clk); frame_end = 1;
    @(negedge clk); frame_end = 0;
    chk("R10 frame_end while on", port_active, 1'b1);
    write(32'h0);
    chk("R10 drain reads one", {rd_data[31], port_active}, 2'b11);
    idle(2);
    chk("R10 drain holds", port_active, 1'b1);
    @(negedge clk); frame_end = 1;
    @(negedge clk); frame_end = 0;
    chk("R10 drained", {rd_data[31], port_active}, 2'b00);
  endtask

  initial begin
    idle(3);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    t_reset;
    t_sticky;
    t_w1c;
    t_live;
    t_irq;
    t_dma;
    t_flush;
    t_srst;
    t_pen;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule